// File: doc/BRIEF.md
# Framed Multi-Channel ADC Serial Output Emulator

This block acts as the serial output stage of a multi-channel 12-bit converter, for use as a stimulus source for a receiver or deserializer elsewhere in the chip. It takes one parallel set of samples per conversion for 2 or 4 channels. It drives a frame signal, a forwarded data clock and one serial lane for each pair of channels. Within a pair, the odd-numbered channel is sent while the frame is high and the even-numbered channel while it is low.

All timing comes from one fast clock that runs at four times the serial bit rate, so every serial bit lasts four fast-clock cycles. The data clock runs at double data rate: each of its edges falls in the middle of a bit, a quarter of its own period after the bit changes. A 12-bit sample is split over two consecutive frames. The upper six bits go in the first frame and the lower six bits in the second. A full sample period therefore lasts 24 bits, or 96 fast cycles. A resync input silences the outputs and restarts the pattern so that the first slot after it belongs to channel 1.

Top module: `adc_frame_ser`

## Requirements
- R1: A synchronous active-high `rst` drives `frame_out`, `dclk_out` and `lane_out` low on the next cycle and clears the held samples to zero. The first cycle after reset in which `resync` is low starts bit 0 of a sample period, with the frame high.
- R2: Counting from the start of a sample period, `frame_out` is high for 6 bit times (24 fast cycles) and then low for 6 bit times. This repeats with a period of 48 fast cycles, and each frame edge coincides with a bit boundary.
- R3: `dclk_out` has a period of 8 fast cycles. It is low for the first two cycles of bit 0, rises two cycles into every even-numbered bit and falls two cycles into every odd-numbered bit, so it never changes in the same cycle as a lane bit.
- R4: Each serial bit is held for 4 fast cycles and sent most significant bit first. The odd channel of the pair is on the lane while `frame_out` is high and the even channel while it is low.
- R5: In a 24-bit sample period, bits 0-5 carry the odd channel's bits 11..6, bits 6-11 the even channel's bits 11..6, bits 12-17 the odd channel's bits 5..0 and bits 18-23 the even channel's bits 5..0.
- R6: Channel k (counting from 0) occupies `smp_data[12k+11:12k]`. `lane_out[j]` carries channel 2j while the frame is high and channel 2j+1 while it is low.
- R7: A sample set presented with `smp_valid` is taken into use only at the start of the next sample period, or at once if it is presented in the cycle just before that start. Among several sets that arrive in one period the last one wins. With no new set, the previous set is sent again.
- R8: While `resync` is sampled high, the next cycle shows `frame_out`, `dclk_out` and every lane low. The first cycle after `resync` is released is bit 0, phase 0 of a period, carrying channel 1 with the frame high.
- R9: The parameter `CH_COUNT` accepts only 2 or 4, and the block provides `CH_COUNT/2` serial lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Holds outputs low and restarts framing on release |
| smp_valid | input | 1 | Strobe marking a new sample set on `smp_data` |
| smp_data | input | CH_COUNT*12 | Packed samples, channel 0 in the low 12 bits |
| frame_out | output | 1 | Frame signal, high during odd-channel slots |
| dclk_out | output | 1 | Forwarded double-data-rate bit clock |
| lane_out | output | CH_COUNT/2 | Serial data, one lane per channel pair |

## Verification
The assertions assume that `rst` is held for more than one cycle, and that `resync` and `smp_valid` only change between clock edges. They also assume that a `resync` pulse may be of any length, so the checks on clock and data edges exclude the cycle in which a resync or reset takes effect. The stimulus drives all inputs on the falling edge. Its random resync pulses last 6 to 10 cycles and its strobes come at a rate of about one in twenty cycles. It also aims directed strobes at mid-period points and at the exact cycle before a period boundary.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_role_e;

    // Bit clock level: rises mid even bit, falls mid odd bit.
    function automatic logic dclk_level(input logic bit_is_odd, input logic past_mid);
        return bit_is_odd ^ past_mid;
    endfunction

endpackage

// File: rtl/adc_ser_timing.sv
module adc_ser_timing
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int BIT_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        resync,
    output logic                        start_d,
    output logic                        running,
    output logic                        frame,
    output logic                        dclk,
    output slot_role_e                  role,
    output logic [$clog2(SAMPLE_W)-1:0] bit_sel
);
    localparam int SLOT_BITS   = SAMPLE_W / 2;
    localparam int PERIOD_BITS = 2 * SAMPLE_W;
    localparam int PH_W        = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam int BI_W        = $clog2(PERIOD_BITS);
    localparam int SEL_W       = $clog2(SAMPLE_W);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYCLES - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(BIT_CYCLES / 2);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(PERIOD_BITS - 1);
    localparam logic [BI_W-1:0] BI_SW   = BI_W'(SAMPLE_W);
    localparam logic [BI_W-1:0] BI_MSB  = BI_W'(SAMPLE_W - 1);
    localparam logic [BI_W-1:0] BI_SLOT = BI_W'(SLOT_BITS);

    typedef struct packed {
        logic            run;
        logic [PH_W-1:0] ph;
        logic [BI_W-1:0] bi;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d    = tm_q;
        start_d = 1'b0;
        if (resync) begin
            tm_d = '0;
        end else if (!tm_q.run) begin
            tm_d.run = 1'b1;
            tm_d.ph  = '0;
            tm_d.bi  = '0;
            start_d  = 1'b1;
        end else if (tm_q.ph == PH_LAST) begin
            tm_d.ph = '0;
            if (tm_q.bi == BI_LAST) begin
                tm_d.bi = '0;
                start_d = 1'b1;
            end else begin
                tm_d.bi = tm_q.bi + 1'b1;
            end
        end else begin
            tm_d.ph = tm_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    logic            lower_half;
    logic            odd_slot;
    logic [BI_W-1:0] rel;
    logic [BI_W-1:0] pos;
    logic [BI_W-1:0] idx;

    always_comb begin
        lower_half = (tm_q.bi >= BI_SW);
        rel        = lower_half ? (tm_q.bi - BI_SW) : tm_q.bi;
        odd_slot   = (rel < BI_SLOT);
        pos        = odd_slot ? rel : (rel - BI_SLOT);
        idx        = BI_MSB - (lower_half ? BI_SLOT : '0) - pos;
        running    = tm_q.run;
        frame      = tm_q.run & odd_slot;
        dclk       = tm_q.run & dclk_level(tm_q.bi[0], tm_q.ph >= PH_MID);
        role       = odd_slot ? SLOT_ODD : SLOT_EVEN;
        bit_sel    = SEL_W'(idx);
    end

endmodule

// File: rtl/adc_ser_sample_buf.sv
module adc_ser_sample_buf #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              load,
    output logic [WORD_W-1:0] active
);
    typedef struct packed {
        logic [WORD_W-1:0] act;
        logic [WORD_W-1:0] pend;
        logic              pend_v;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (smp_valid) begin
            buf_d.pend   = smp_data;
            buf_d.pend_v = 1'b1;
        end
        if (load && buf_d.pend_v) begin
            buf_d.act    = buf_d.pend;
            buf_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) buf_q <= '0;
        else     buf_q <= buf_d;
    end

    assign active = buf_q.act;

endmodule

// File: rtl/adc_ser_lane.sv
module adc_ser_lane
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0]         odd_word,
    input  logic [SAMPLE_W-1:0]         even_word,
    input  slot_role_e                  role,
    input  logic                        running,
    input  logic [$clog2(SAMPLE_W)-1:0] bit_sel,
    output logic                        bit_out
);
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        word    = (role == SLOT_ODD) ? odd_word : even_word;
        bit_out = running & word[bit_sel];
    end

endmodule

// File: rtl/adc_frame_ser.sv
module adc_frame_ser
    import adc_ser_pkg::*;
#(
    parameter int CH_COUNT   = 4,
    parameter int SAMPLE_W   = 12,
    parameter int BIT_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         resync,
    input  logic                         smp_valid,
    input  logic [CH_COUNT*SAMPLE_W-1:0] smp_data,
    output logic                         frame_out,
    output logic                         dclk_out,
    output logic [CH_COUNT/2-1:0]        lane_out
);
    localparam int LANES  = CH_COUNT / 2;
    localparam int WORD_W = CH_COUNT * SAMPLE_W;
    localparam int SEL_W  = $clog2(SAMPLE_W);

    if (CH_COUNT != 2 && CH_COUNT != 4) begin : g_bad_count
        $error("CH_COUNT must be 2 or 4 (R9)");
    end

    logic             start_d;
    logic             running;
    slot_role_e       role;
    logic [SEL_W-1:0] bit_sel;
    logic [WORD_W-1:0] active;

    adc_ser_timing #(
        .SAMPLE_W  (SAMPLE_W),
        .BIT_CYCLES(BIT_CYCLES)
    ) u_timing (
        .clk    (clk),
        .rst    (rst),
        .resync (resync),
        .start_d(start_d),
        .running(running),
        .frame  (frame_out),
        .dclk   (dclk_out),
        .role   (role),
        .bit_sel(bit_sel)
    );

    adc_ser_sample_buf #(
        .WORD_W(WORD_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .load     (start_d),
        .active   (active)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adc_ser_lane #(
            .SAMPLE_W(SAMPLE_W)
        ) u_lane (
            .odd_word (active[(2*g)*SAMPLE_W +: SAMPLE_W]),
            .even_word(active[(2*g+1)*SAMPLE_W +: SAMPLE_W]),
            .role     (role),
            .running  (running),
            .bit_sel  (bit_sel),
            .bit_out  (lane_out[g])
        );
    end

endmodule

// File: rtl/adc_frame_ser_chk.sv
module adc_frame_ser_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             resync,
    input logic             frame_out,
    input logic             dclk_out,
    input logic [LANES-1:0] lane_out
);

    AST_RESYNC_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(resync) |-> (!frame_out && !dclk_out && lane_out == '0)); // R8

    AST_BIT_EDGE_APART: assert property (@(posedge clk) disable iff (rst)
        (!$past(resync) && !$past(rst) && !$stable(lane_out)) |-> $stable(dclk_out)); // R3

    AST_FRAME_EDGE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_out) |-> !dclk_out); // R2

    AST_DCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($rose(dclk_out) && !resync) |=> dclk_out); // R3

endmodule

bind adc_frame_ser adc_frame_ser_chk #(
    .LANES(CH_COUNT / 2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .resync   (resync),
    .frame_out(frame_out),
    .dclk_out (dclk_out),
    .lane_out (lane_out)
);

// File: tb/tb_adc_frame_ser.sv
module tb_adc_frame_ser;
    localparam int CLK_PERIOD = 10;
    localparam int CH     = 4;
    localparam int SW     = 12;
    localparam int BC     = 4;
    localparam int LN     = CH / 2;
    localparam int PERIOD = 2 * SW * BC;
    localparam int SEED   = 32'h5EED_0A11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic resync = 1'b0;
    logic smp_valid = 1'b0;
    logic [CH*SW-1:0] smp_data = '0;
    logic frame_out, dclk_out;
    logic [LN-1:0] lane_out;

    adc_frame_ser #(.CH_COUNT(CH), .SAMPLE_W(SW), .BIT_CYCLES(BC)) dut (
        .clk(clk), .rst(rst), .resync(resync), .smp_valid(smp_valid),
        .smp_data(smp_data), .frame_out(frame_out), .dclk_out(dclk_out),
        .lane_out(lane_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit mrst, mrun, mpv;
    int mt;
    logic [CH*SW-1:0] mact, mpend;

    task automatic chk(string rq, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Model of the last posedge, from the inputs present at that edge.
    task automatic advance();
        mrst = rst;
        if (rst) begin
            mrun = 0; mt = 0; mact = '0; mpend = '0; mpv = 0;
        end else begin
            if (smp_valid) begin mpend = smp_data; mpv = 1; end
            if (resync) begin
                mrun = 0; mt = 0;
            end else begin
                if (!mrun) begin mrun = 1; mt = 0; end
                else mt = (mt + 1) % PERIOD;
                if (mt == 0 && mpv) begin mact = mpend; mpv = 0; end
            end
        end
    endtask

    task automatic step();
        int bitn, rel, pos, ch, idx;
        bit fr, half, dk;
        @(negedge clk);
        advance();
        if (mrst || !mrun) begin
            chk(mrst ? "R1" : "R8", "frame", frame_out, 1'b0);
            chk(mrst ? "R1" : "R8", "dclk", dclk_out, 1'b0);
            for (int l = 0; l < LN; l++)
                chk(mrst ? "R1" : "R8", "lane", lane_out[l], 1'b0);
        end else begin
            bitn = mt / BC;
            rel  = bitn % SW;
            fr   = rel < SW/2;
            half = bitn >= SW;
            pos  = rel % (SW/2);
            dk   = ((bitn % 2) == 1) != ((mt % BC) >= BC/2);
            chk("R2", "frame", frame_out, fr);
            chk("R3", "dclk", dclk_out, dk);
            for (int l = 0; l < LN; l++) begin
                ch  = fr ? 2*l : 2*l + 1;
                idx = SW - 1 - (half ? SW/2 : 0) - pos;
                chk(tag, "lane", lane_out[l], mact[ch*SW + idx]);
            end
        end
    endtask

    task automatic send(logic [CH*SW-1:0] v);
        smp_data = v; smp_valid = 1; step(); smp_valid = 0;
    endtask

    task automatic wait_mt(int target);
        while (!(mrun && mt == target)) step();
    endtask

    logic [CH*SW-1:0] rnd;
    int sync_left;

    initial begin
        void'($urandom(SEED));
        // R1: reset state and first period
        repeat (4) step();
        rst = 0;
        tag = "R1";
        repeat (20) step();
        // R4: basic bit order and role by frame polarity
        tag = "R4";
        send({12'h0F0, 12'h5A3, 12'h3C6, 12'hA5C});
        repeat (2*PERIOD) step();
        // R5: upper and lower halves distinguishable
        tag = "R5";
        send({12'h03F, 12'hFC0, 12'h03F, 12'hFC0});
        repeat (2*PERIOD) step();
        // R6: distinct channels, channel placement per lane
        tag = "R6";
        send({12'hABC, 12'h789, 12'h456, 12'h123});
        repeat (2*PERIOD) step();
        // R7: mid-period arrivals held; last wins; boundary arrival used at once
        tag = "R7";
        wait_mt(40);
        send({12'h111, 12'h222, 12'h333, 12'h444});
        wait_mt(60);
        send({12'hE01, 12'h7F2, 12'h0C3, 12'h9B4});
        repeat (PERIOD + 10) step();
        wait_mt(PERIOD - 1);
        send({12'h801, 12'h402, 12'h203, 12'hF04});
        repeat (PERIOD) step();
        // R8: resync silences and restarts at channel 1; strobe during resync
        tag = "R8";
        wait_mt(50);
        resync = 1;
        repeat (3) step();
        send({12'h00F, 12'hF00, 12'h0F0, 12'h5AF});
        repeat (4) step();
        resync = 0;
        repeat (PERIOD + 5) step();
        resync = 1; step(); resync = 0;
        repeat (PERIOD) step();
        // R9: lane count from the channel count
        checks++;
        if ($bits(lane_out) != CH/2) begin
            errors++;
            $display("FAIL R9 lane count actual=%0d expected=%0d", $bits(lane_out), CH/2);
        end
        // R9: random mix over all lanes
        tag = "R9";
        sync_left = 0;
        for (int n = 0; n < 3000; n++) begin
            if (sync_left > 0) begin
                sync_left--;
                resync = (sync_left != 0);
            end else if ($urandom_range(299) == 0) begin
                sync_left = 6 + $urandom_range(4);
                resync = 1;
            end
            rnd = {$urandom, $urandom};
            smp_data  = rnd;
            smp_valid = ($urandom_range(19) == 0);
            step();
        end
        smp_valid = 0; resync = 0;
        repeat (PERIOD) step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule